// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block feeds a pulse-swallow feedback counter with one integer divide value per modulator clock. Over many cycles the average of those values equals an integer base ratio plus a signed fraction of a fixed modulus of 62976. The fraction arrives as a 17-bit two's-complement word whose legal span is -31488 to +31488. With the modulator clocked at 9.84 MHz, one unit of the fraction moves the synthesised frequency by 10 kHz/64.

The fraction is turned into carries by an error-feedback accumulator. A first-order setting uses one accumulator stage. A second-order setting cascades two stages and differentiates the second carry, which pushes the quantisation error to higher frequencies. With the fractional mode bit low, the base ratio goes straight to the output and both stages are held at zero.

The mode is tracked by three states:
- `ST_INT`: integer pass-through.
- `ST_FRAC1`: first-order modulation.
- `ST_FRAC2`: second-order modulation.

The next state is chosen at every edge from the inputs:
- `frac_en` low leads to `ST_INT`.
- `frac_en` high with `order2` low leads to `ST_FRAC1`.
- `frac_en` high with `order2` high leads to `ST_FRAC2`.

All six transitions between distinct states, and the three self-loops, are allowed. The output register and the accumulators update on the same edge. Any change of the inputs therefore appears at the output one clock later, in a single step.

Top module: `fnm_divmod`

## Requirements
- R1: While `rst_n` is low at a clock edge, `div_out` becomes 0 and both accumulators and the delayed carry become 0.
- R2: When `frac_en` is low at an edge, `div_out` takes `n_int` unchanged on that edge and both accumulators and the delayed carry are cleared. A later entry into fractional mode therefore starts from zero.
- R3: `f_word` is read as 17-bit two's complement. Values above +31488 or below -31488 are illegal and are used as a fraction of 0.
- R4: In first-order mode (`frac_en`=1, `order2`=0), each edge computes s = acc1 + F, with acc1 kept in [0, 62976).
  - If s >= 62976, acc1 becomes s - 62976 and the carry c1 is +1.
  - If s < 0, acc1 becomes s + 62976 and c1 is -1.
  - Otherwise acc1 becomes s and c1 is 0.
  - `div_out` becomes Neff + c1.
- R5: In second-order mode (`order2`=1), the first stage works as in R4. The second stage then computes t = acc2 + new acc1.
  - If t >= 62976, acc2 becomes t - 62976 and c2 is 1; otherwise acc2 becomes t and c2 is 0.
  - `div_out` becomes Neff + c1 + c2 - c2p, where c2p is the c2 of the previous edge.
- R6: Starting from cleared accumulators with a fixed legal F, the sum of (`div_out` - Neff) over 62976 consecutive cycles equals F exactly in first order. In second order it equals F or F+1.
- R7: In fractional mode, Neff is `n_int` limited to the range 72..1008. An `n_int` below 72 counts as 72, and one above 1008 counts as 1008.
- R8: `cnt_clr` high at an edge in fractional mode clears both accumulators and the delayed carry, and `div_out` becomes Neff. In integer mode `cnt_clr` has no effect on `div_out`.
- R9: Whenever the mode is not second order, the second accumulator and the delayed carry are held at 0. On returning to second order, the first output therefore has c2p = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_clr | input | 1 | Counter reset: clears the accumulators |
| frac_en | input | 1 | 1 = fractional mode, 0 = integer pass-through |
| order2 | input | 1 | 1 = second-order modulation, 0 = first order |
| n_int | input | 10 | Integer base divide ratio |
| f_word | input | 17 | Signed fractional word, two's complement |
| div_out | output | 10 | Registered instantaneous divide value |

## Verification
The hardest situation to reach is an exact long-run average, because it appears only after a full wrap of the 62976-state accumulator. The bench clears the accumulators, holds one fraction for 62976 cycles in each order and sums the offsets. Along the way it compares every cycle against an arithmetic model. A second hard spot is the delayed second-stage carry left over across a mode change. Order switches are made at arbitrary accumulator phases so that a pending carry must be discarded.

// File: rtl/fnm_pkg.sv
package fnm_pkg;
    typedef enum logic [1:0] {
        ST_INT   = 2'd0,
        ST_FRAC1 = 2'd1,
        ST_FRAC2 = 2'd2
    } fnm_state_e;
endpackage

// File: rtl/fnm_range_guard.sv
module fnm_range_guard #(
    parameter int NW   = 10,
    parameter int FW   = 17,
    parameter int FMAX = 31488,
    parameter int NMIN = 72,
    parameter int NMAX = 1008
) (
    input  logic [NW-1:0]        n_int,
    input  logic [FW-1:0]        f_word,
    output logic [NW-1:0]        n_sat,
    output logic signed [FW-1:0] f_eff
);
    localparam logic signed [FW-1:0] F_HI = FW'(FMAX);
    localparam logic signed [FW-1:0] F_LO = FW'(-FMAX);
    localparam logic [NW-1:0]        N_LO = NW'(NMIN);
    localparam logic [NW-1:0]        N_HI = NW'(NMAX);

    logic f_ok;

    always_comb begin
        f_ok  = ($signed(f_word) <= F_HI) && ($signed(f_word) >= F_LO);
        f_eff = f_ok ? $signed(f_word) : '0;
        if (n_int < N_LO)
            n_sat = N_LO;
        else if (n_int > N_HI)
            n_sat = N_HI;
        else
            n_sat = n_int;
    end
endmodule

// File: rtl/fnm_accum_stage.sv
module fnm_accum_stage #(
    parameter int AW  = 18,
    parameter int MOD = 62976
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic signed [AW-1:0] add_in,
    output logic signed [AW-1:0] acc_d,
    output logic signed [1:0]    carry
);
    localparam logic signed [AW-1:0] MODS = AW'(MOD);

    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] sum;

    always_comb begin
        sum = acc_q + add_in;
        if (sum >= MODS) begin
            acc_d = sum - MODS;
            carry = 2'sd1;
        end else if (sum < 0) begin
            acc_d = sum + MODS;
            carry = -2'sd1;
        end else begin
            acc_d = sum;
            carry = 2'sd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end
endmodule

// File: rtl/fnm_divmod.sv
module fnm_divmod
    import fnm_pkg::*;
#(
    parameter int NW   = 10,
    parameter int FW   = 17,
    parameter int FMAX = 31488,
    parameter int NMIN = 72,
    parameter int NMAX = 1008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_clr,
    input  logic          frac_en,
    input  logic          order2,
    input  logic [NW-1:0] n_int,
    input  logic [FW-1:0] f_word,
    output logic [NW-1:0] div_out
);
    localparam int MOD = 2 * FMAX;
    localparam int AW  = $clog2(MOD) + 2;

    fnm_state_e state_q, state_d;

    logic [NW-1:0]        n_sat;
    logic signed [FW-1:0] f_eff;
    logic signed [AW-1:0] f_ext;
    logic signed [AW-1:0] s1_acc_d, s2_acc_d;
    logic signed [1:0]    c1, c2, c2d_q, c2d_use;
    logic signed [3:0]    ofs;
    logic                 s1_clr, s2_clr;
    logic [NW-1:0]        div_d;

    fnm_range_guard #(
        .NW(NW), .FW(FW), .FMAX(FMAX), .NMIN(NMIN), .NMAX(NMAX)
    ) u_guard (
        .n_int (n_int),
        .f_word(f_word),
        .n_sat (n_sat),
        .f_eff (f_eff)
    );

    assign f_ext = {{(AW-FW){f_eff[FW-1]}}, f_eff};

    // Mode selection: the state for this edge follows the inputs directly.
    always_comb begin
        if (!frac_en)
            state_d = ST_INT;
        else if (order2)
            state_d = ST_FRAC2;
        else
            state_d = ST_FRAC1;
    end

    assign s1_clr = cnt_clr || (state_d == ST_INT);
    assign s2_clr = cnt_clr || (state_d != ST_FRAC2);

    fnm_accum_stage #(.AW(AW), .MOD(MOD)) u_stage1 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (s1_clr),
        .add_in(f_ext),
        .acc_d (s1_acc_d),
        .carry (c1)
    );

    fnm_accum_stage #(.AW(AW), .MOD(MOD)) u_stage2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (s2_clr),
        .add_in(s1_acc_d),
        .acc_d (s2_acc_d),
        .carry (c2)
    );

    // Delayed second carry only counts if the last edge ran second order.
    assign c2d_use = (state_q == ST_FRAC2) ? c2d_q : 2'sd0;

    // Output process.
    always_comb begin
        ofs = 4'sd0;
        unique case (state_d)
            ST_INT: begin
                div_d = n_int;
            end
            ST_FRAC1: begin
                if (!cnt_clr)
                    ofs = {{2{c1[1]}}, c1};
                div_d = n_sat + {{(NW-4){ofs[3]}}, ofs};
            end
            ST_FRAC2: begin
                if (!cnt_clr)
                    ofs = {{2{c1[1]}}, c1} + {{2{c2[1]}}, c2}
                        - {{2{c2d_use[1]}}, c2d_use};
                div_d = n_sat + {{(NW-4){ofs[3]}}, ofs};
            end
            default: begin
                div_d = n_int;
            end
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INT;
            c2d_q   <= 2'sd0;
            div_out <= '0;
        end else begin
            state_q <= state_d;
            c2d_q   <= cnt_clr ? 2'sd0 : c2;
            div_out <= div_d;
        end
    end

    logic unused_s2;
    assign unused_s2 = ^s2_acc_d;
endmodule

// File: rtl/fnm_divmod_chk.sv
module fnm_divmod_chk #(
    parameter int NW   = 10,
    parameter int FW   = 17,
    parameter int FMAX = 31488,
    parameter int NMIN = 72,
    parameter int NMAX = 1008
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_clr,
    input logic          frac_en,
    input logic          order2,
    input logic [NW-1:0] n_int,
    input logic [FW-1:0] f_word,
    input logic [NW-1:0] div_out
);
    logic f_bad, n_in;
    assign f_bad = ($signed(f_word) > $signed(FW'(FMAX)))
                || ($signed(f_word) < $signed(FW'(-FMAX)));
    assign n_in  = (n_int >= NW'(NMIN)) && (n_int <= NW'(NMAX));

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> div_out == '0);

    // R2
    a_r2_int_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !frac_en |=> div_out == $past(n_int));

    // R3
    a_r3_illegal_as_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_en && !order2 && f_bad && n_in) |=> div_out == $past(n_int));

    // R4
    a_r4_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_en && !order2 && f_word == '0 && n_in) |=> div_out == $past(n_int));

    // R7
    a_r7_frac_window: assert property (@(posedge clk) disable iff (!rst_n)
        frac_en |=> (div_out >= NW'(NMIN-2)) && (div_out <= NW'(NMAX+2)));

    // R8
    a_r8_clr_base: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_en && cnt_clr && n_in) |=> div_out == $past(n_int));
endmodule

bind fnm_divmod fnm_divmod_chk #(
    .NW(NW), .FW(FW), .FMAX(FMAX), .NMIN(NMIN), .NMAX(NMAX)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_clr(cnt_clr),
    .frac_en(frac_en),
    .order2 (order2),
    .n_int  (n_int),
    .f_word (f_word),
    .div_out(div_out)
);

// File: tb/fnm_divmod_tb.sv
module fnm_divmod_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW  = 10;
    localparam int FW  = 17;
    localparam int M   = 62976;
    localparam int FMX = 31488;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_clr = 1'b0;
    logic          frac_en = 1'b0;
    logic          order2 = 1'b0;
    logic [NW-1:0] n_int = '0;
    logic [FW-1:0] f_word = '0;
    logic [NW-1:0] div_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_a1 = 0, m_a2 = 0, m_c2d = 0;
    int last_ofs = 0;
    int last_neff = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fnm_divmod u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .frac_en(frac_en),
        .order2(order2), .n_int(n_int), .f_word(f_word), .div_out(div_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance the arithmetic model with the present inputs, clock once, compare.
    task automatic tick(input string tag_in);
        int n, f, neff, s, t, c1, c2, ofs, exp;
        string tag;
        bit legal;
        n = int'(n_int);
        f = int'($signed(f_word));
        legal = (f <= FMX) && (f >= -FMX);
        neff = (n < 72) ? 72 : (n > 1008) ? 1008 : n;
        ofs = 0;
        if (!frac_en) begin
            m_a1 = 0; m_a2 = 0; m_c2d = 0;
            exp = n; tag = "R2";
        end else if (cnt_clr) begin
            m_a1 = 0; m_a2 = 0; m_c2d = 0;
            exp = neff; tag = "R8";
        end else begin
            s = m_a1 + (legal ? f : 0);
            if (s >= M) begin s -= M; c1 = 1; end
            else if (s < 0) begin s += M; c1 = -1; end
            else c1 = 0;
            m_a1 = s;
            if (order2) begin
                t = m_a2 + m_a1;
                c2 = (t >= M) ? 1 : 0;
                m_a2 = t - c2 * M;
                ofs = c1 + c2 - m_c2d;
                m_c2d = c2;
            end else begin
                m_a2 = 0; m_c2d = 0;
                ofs = c1;
            end
            exp = neff + ofs;
            if (!legal) tag = "R3";
            else if (n != neff) tag = "R7";
            else if (order2) tag = "R5";
            else tag = "R4";
        end
        if (tag_in != "") tag = tag_in;
        last_ofs = ofs;
        last_neff = neff;
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(div_out), exp);
    endtask

    task automatic clr_tick();
        cnt_clr = 1'b1;
        tick("");
        cnt_clr = 1'b0;
    endtask

    task automatic period_sum(input int f, input bit o2);
        int sum;
        frac_en = 1'b1; order2 = o2; n_int = 10'd600; f_word = FW'(f);
        clr_tick();
        sum = 0;
        for (int k = 0; k < M; k++) begin
            tick("");
            sum += last_ofs;
        end
        if (!o2) check("R6 first order", sum, f);
        else check("R6 second order", (sum == f || sum == f + 1) ? f : sum, f);
    endtask

    initial begin
        int fl[10];
        int nl[3];
        fl = '{0, 1, -1, 31488, -31488, 12345, -20000, 31489, -31489, -65536};
        nl = '{72, 500, 1008};

        // R1: reset holds output at zero even with fractional stimulus present
        frac_en = 1'b1; n_int = 10'd300; f_word = 17'd30000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(div_out), 0);
        rst_n = 1'b1;
        m_a1 = 0; m_a2 = 0; m_c2d = 0;

        // R2: pass-through, including values outside the fractional range
        frac_en = 1'b0;
        for (int v = 0; v < 1024; v += 73) begin
            n_int = NW'(v);
            tick("R2");
        end
        // R8: counter reset ignored in integer mode
        n_int = 10'd1023; cnt_clr = 1'b1; tick("R8"); cnt_clr = 1'b0;

        // R3/R4/R5: sweep fractions, orders and base ratios
        for (int o = 0; o < 2; o++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 3; j++) begin
                    frac_en = 1'b1; order2 = o[0];
                    n_int = NW'(nl[j]); f_word = FW'(fl[i]);
                    clr_tick();
                    repeat (150) tick("");
                end
            end
        end

        // R7: clamping of the base ratio
        for (int o = 0; o < 2; o++) begin
            order2 = o[0]; f_word = 17'd5000;
            n_int = 10'd10;   repeat (100) tick("R7");
            n_int = 10'd1023; repeat (100) tick("R7");
            n_int = 10'd0;    repeat (20)  tick("R7");
        end

        // R8: mid-stream clear
        n_int = 10'd400; f_word = FW'(-27000); order2 = 1'b1;
        repeat (37) tick("");
        clr_tick();
        repeat (30) tick("");

        // R9: order and mode switches at arbitrary phases
        f_word = FW'(-12345); n_int = 10'd250;
        for (int r = 0; r < 6; r++) begin
            order2 = 1'b1; repeat (17 + r) tick("R9");
            order2 = 1'b0; repeat (3 + r)  tick("R9");
            order2 = 1'b1; repeat (9)      tick("R9");
            frac_en = 1'b0; repeat (2)     tick("R9");
            frac_en = 1'b1; repeat (11)    tick("R9");
        end

        // R6: exact average over a full modulus period
        period_sum(12345, 1'b0);
        period_sum(-7001, 1'b1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 195000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule